// File: doc/BRIEF.md
# Port-Mapped Configuration Access Bridge

This bridge sits on the host's I/O bus and turns the legacy two-port configuration scheme into transactions on a simple downstream configuration interface. Software first writes a 32-bit selector to the address port. The selector carries an enable flag and a target bus, device, function and dword-aligned register offset. A later read or write of the data port then becomes one configuration read or write at that target. The downstream side returns one dword and a flag that says whether a device answered.

I/O accesses to any other port address are not touched. They pass straight through to a downstream I/O bus and their completion is returned to the host unchanged. The host-side access stalls until the bridge acknowledges it. Only one configuration transaction is ever in flight.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the selector is all zero: a read of the address port (0xCF8) returns 0x00000000 and no configuration request is raised.
- R2: A write to the address port latches the selector. A read of the address port returns the latched value with bits 30:24 and bits 1:0 always zero.
- R3: While selector bit 31 is set, a data-port (0xCFC) read issues exactly one configuration read with cfg_we=0. The request carries bus = selector[23:16], device = selector[15:11], function = selector[10:8] and register = selector[7:2] followed by two zero bits. The host receives cfg_rdata.
- R4: While selector bit 31 is set, a data-port write issues exactly one configuration write with cfg_we=1, the same target fields as R3 and cfg_wdata equal to the host write data.
- R5: While selector bit 31 is clear, a data-port read returns 0xFFFFFFFF and raises no configuration request.
- R6: While selector bit 31 is clear, a data-port write is dropped: no configuration request is raised.
- R7: A configuration read that completes with cfg_hit=0 returns 0xFFFFFFFF to the host.
- R8: A configuration request stays asserted, with stable target, direction and data, until cfg_ack. The host access is not acknowledged before that, so at most one transaction is outstanding.
- R9: Host accesses to any port other than 0xCF8 and 0xCFC appear unchanged on the pass-through I/O bus: the same address, direction and write data. Their pt_ack and pt_rdata are returned as io_ack and io_rdata. Accesses to 0xCF8 and 0xCFC never appear on the pass-through bus.
- R10: Every access to the address or data port is acknowledged by an io_ack pulse exactly one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | Host I/O request, held until io_ack |
| io_we | input | 1 | Host access is a write |
| io_addr | input | IO_AW | Host I/O port address |
| io_wdata | input | 32 | Host write data |
| io_ack | output | 1 | Host access completes |
| io_rdata | output | 32 | Host read data, valid with io_ack |
| cfg_req | output | 1 | Configuration request, held until cfg_ack |
| cfg_we | output | 1 | Configuration write |
| cfg_bus | output | 8 | Target bus number |
| cfg_dev | output | 5 | Target device number |
| cfg_fn | output | 3 | Target function number |
| cfg_reg | output | 8 | Dword-aligned register offset |
| cfg_wdata | output | 32 | Configuration write data |
| cfg_ack | input | 1 | Configuration completion, one cycle |
| cfg_hit | input | 1 | A device answered the request |
| cfg_rdata | input | 32 | Configuration read data |
| pt_req | output | 1 | Pass-through I/O request |
| pt_we | output | 1 | Pass-through write |
| pt_addr | output | IO_AW | Pass-through port address |
| pt_wdata | output | 32 | Pass-through write data |
| pt_ack | input | 1 | Pass-through completion |
| pt_rdata | input | 32 | Pass-through read data |

## Verification
The embedded properties assume that the host holds io_req and its address, direction and data steady until io_ack, and drops io_req on the edge that ends the acknowledge cycle. They also assume that cfg_ack is a single-cycle pulse sent only while cfg_req is high. The directed stimulus keeps to both rules. Every host access goes through one task that waits for io_ack and releases the request at once. The bench's configuration responder answers only an open request, after a latency that can be changed, and drops its acknowledge after one cycle.

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge #(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'hCF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'hCFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_req,
  input  logic             io_we,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [31:0]      io_wdata,
  output logic             io_ack,
  output logic [31:0]      io_rdata,
  output logic             cfg_req,
  output logic             cfg_we,
  output logic [7:0]       cfg_bus,
  output logic [4:0]       cfg_dev,
  output logic [2:0]       cfg_fn,
  output logic [7:0]       cfg_reg,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_ack,
  input  logic             cfg_hit,
  input  logic [31:0]      cfg_rdata,
  output logic             pt_req,
  output logic             pt_we,
  output logic [IO_AW-1:0] pt_addr,
  output logic [31:0]      pt_wdata,
  input  logic             pt_ack,
  input  logic [31:0]      pt_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_CFG, S_RESP} state_t;

  state_t      state;
  logic        en_q;
  logic [7:0]  bus_q;
  logic [4:0]  dev_q;
  logic [2:0]  fn_q;
  logic [5:0]  reg_q;
  logic [31:0] rdata_q;
  logic        req_q;
  logic        we_q;
  logic [31:0] wdata_q;

  wire hit_addr = (io_addr == ADDR_PORT);
  wire hit_data = (io_addr == DATA_PORT);
  wire pt_sel   = io_req && !(hit_addr || hit_data);
  wire [31:0] sel_view = {en_q, 7'd0, bus_q, dev_q, fn_q, reg_q, 2'b00};

  assign pt_req   = pt_sel;
  assign pt_we    = io_we;
  assign pt_addr  = io_addr;
  assign pt_wdata = io_wdata;

  assign cfg_req   = req_q;
  assign cfg_we    = we_q;
  assign cfg_wdata = wdata_q;
  assign cfg_bus   = bus_q;
  assign cfg_dev   = dev_q;
  assign cfg_fn    = fn_q;
  assign cfg_reg   = {reg_q, 2'b00};

  assign io_ack   = (state == S_RESP) || (pt_sel && pt_ack);
  assign io_rdata = pt_sel ? pt_rdata : rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      en_q    <= 1'b0;
      bus_q   <= '0;
      dev_q   <= '0;
      fn_q    <= '0;
      reg_q   <= '0;
      rdata_q <= '0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (io_req && hit_addr) begin
            if (io_we) begin
              en_q  <= io_wdata[31];
              bus_q <= io_wdata[23:16];
              dev_q <= io_wdata[15:11];
              fn_q  <= io_wdata[10:8];
              reg_q <= io_wdata[7:2];
            end
            rdata_q <= sel_view;
            state   <= S_RESP;
          end else if (io_req && hit_data) begin
            if (en_q) begin
              req_q   <= 1'b1;
              we_q    <= io_we;
              wdata_q <= io_wdata;
              state   <= S_CFG;
            end else begin
              rdata_q <= '1;
              state   <= S_RESP;
            end
          end
        end
        S_CFG: begin
          if (cfg_ack) begin
            req_q   <= 1'b0;
            rdata_q <= cfg_hit ? cfg_rdata : '1;
            state   <= S_RESP;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !cfg_ack) |=> (cfg_req && $stable({cfg_we, cfg_bus, cfg_dev, cfg_fn, cfg_reg, cfg_wdata})));

  a_r8_no_early_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> !io_ack);

  a_r5_disabled_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && io_req && hit_data && !en_q) |=> !cfg_req);

  a_r9_pt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    pt_req |-> !cfg_req);

  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && io_ack && hit_addr && !io_we) |-> (io_rdata[30:24] == 7'd0 && io_rdata[1:0] == 2'd0));

  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (io_ack && !pt_sel) |=> !(io_ack && !pt_sel));

endmodule

// File: tb/cfg_port_bridge_tb_top.sv
module cfg_port_bridge_tb_top;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic io_req = 0, io_we = 0, io_ack;
  logic [15:0] io_addr = 0;
  logic [31:0] io_wdata = 0, io_rdata;
  logic cfg_req, cfg_we, cfg_ack = 0, cfg_hit = 0;
  logic [7:0] cfg_bus, cfg_reg;
  logic [4:0] cfg_dev;
  logic [2:0] cfg_fn;
  logic [31:0] cfg_wdata, cfg_rdata = 0;
  logic pt_req, pt_we, pt_ack = 0;
  logic [15:0] pt_addr;
  logic [31:0] pt_wdata, pt_rdata;

  cfg_port_bridge dut_i (.*);

  int errors = 0, checks = 0;
  int lat = 1, wait_cnt = 0, req_count = 0, pt_bad = 0, ack_extra = 0;
  logic [7:0] l_bus, l_reg; logic [4:0] l_dev; logic [2:0] l_fn; logic l_we; logic [31:0] l_wdata;
  logic [15:0] p_addr; logic p_we; logic [31:0] p_wdata;

  function automatic logic [31:0] model(input logic [7:0] b, input logic [4:0] d,
                                        input logic [2:0] f, input logic [7:0] r);
    return {b, 3'b000, d, f, 5'b00000, r} ^ 32'h5A5A_0000;
  endfunction

  always @(posedge clk) begin
    if (cfg_ack) begin
      cfg_ack <= 0;
      req_count <= req_count + 1;
      l_bus <= cfg_bus; l_dev <= cfg_dev; l_fn <= cfg_fn; l_reg <= cfg_reg;
      l_we <= cfg_we; l_wdata <= cfg_wdata;
    end else if (cfg_req) begin
      if (wait_cnt + 1 >= lat) begin
        cfg_ack   <= 1;
        cfg_hit   <= (cfg_dev != 5'd31);
        cfg_rdata <= model(cfg_bus, cfg_dev, cfg_fn, cfg_reg);
        wait_cnt  <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  assign pt_rdata = {16'hBEEF, pt_addr};
  always @(posedge clk) begin
    pt_ack <= pt_req && !pt_ack;
    if (pt_req) begin p_addr <= pt_addr; p_we <= pt_we; p_wdata <= pt_wdata; end
    if (pt_req && (pt_addr == 16'hCF8 || pt_addr == 16'hCFC)) pt_bad <= pt_bad + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic io_access(input logic [15:0] a, input logic we, input logic [31:0] wd,
                           output logic [31:0] rd, output int cyc);
    @(negedge clk);
    io_req = 1; io_addr = a; io_we = we; io_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!io_ack && cyc < 100);
    rd = io_rdata;
    io_req = 0;
    @(negedge clk);
    if (io_ack) ack_extra++;
  endtask

  task automatic t_reset();
    logic [31:0] rd; int c;
    chk("R1 cfg_req at reset", {31'd0, cfg_req}, 0);
    io_access(16'hCF8, 0, 0, rd, c);
    chk("R1 selector after reset", rd, 32'h0);
  endtask

  task automatic t_selector();
    logic [31:0] rd; int c;
    io_access(16'hCF8, 1, 32'hFFFF_FFFF, rd, c);
    io_access(16'hCF8, 0, 0, rd, c);
    chk("R2 all ones readback", rd, 32'h80FF_FFFC);
    io_access(16'hCF8, 1, 32'h7F12_3457, rd, c);
    io_access(16'hCF8, 0, 0, rd, c);
    chk("R2 reserved cleared", rd, 32'h0012_3454);
  endtask

  task automatic t_disabled();
    logic [31:0] rd; int c, n;
    n = req_count;
    io_access(16'hCFC, 0, 0, rd, c);
    chk("R5 disabled read data", rd, 32'hFFFF_FFFF);
    chk("R5 no request", req_count, n);
    io_access(16'hCFC, 1, 32'h1234_5678, rd, c);
    repeat (3) @(negedge clk);
    chk("R6 write dropped", req_count, n);
  endtask

  task automatic t_read(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f, input logic [7:0] r);
    logic [31:0] rd; int c, n;
    io_access(16'hCF8, 1, {1'b1, 7'd0, b, d, f, r}, rd, c);
    n = req_count;
    io_access(16'hCFC, 0, 0, rd, c);
    chk("R3 one request", req_count, n + 1);
    chk("R3 fields", {l_we, l_bus, l_dev, l_fn, l_reg}, {1'b0, b, d, f, r & 8'hFC});
    chk("R3 read data", rd, model(b, d, f, r & 8'hFC));
  endtask

  task automatic t_write();
    logic [31:0] rd; int c, n;
    io_access(16'hCF8, 1, 32'h8001_2A10, rd, c);
    n = req_count;
    io_access(16'hCFC, 1, 32'hDEAD_BEEF, rd, c);
    chk("R4 one request", req_count, n + 1);
    chk("R4 write fields", {l_we, l_bus, l_dev, l_fn, l_reg}, {1'b1, 8'h01, 5'h05, 3'h2, 8'h10});
    chk("R4 write data", l_wdata, 32'hDEAD_BEEF);
  endtask

  task automatic t_absent();
    logic [31:0] rd; int c;
    io_access(16'hCF8, 1, {1'b1, 7'd0, 8'h02, 5'd31, 3'd0, 8'h00}, rd, c);
    io_access(16'hCFC, 0, 0, rd, c);
    chk("R7 absent device", rd, 32'hFFFF_FFFF);
  endtask

  task automatic t_stall();
    logic [31:0] rd; int c, n;
    lat = 6;
    io_access(16'hCF8, 1, 32'h8000_0800, rd, c);
    n = req_count;
    io_access(16'hCFC, 0, 0, rd, c);
    chk("R8 stall length", (c >= 7), 1);
    chk("R8 single transaction", req_count, n + 1);
    chk("R8 data after stall", rd, model(0, 1, 0, 0));
    lat = 1;
  endtask

  task automatic t_passthrough();
    logic [31:0] rd; int c, n;
    n = req_count;
    io_access(16'h0080, 1, 32'hCAFE_0001, rd, c);
    chk("R9 pt write", {p_we, p_addr, p_wdata}, {1'b1, 16'h0080, 32'hCAFE_0001});
    io_access(16'hCFD, 0, 0, rd, c);
    chk("R9 pt read data", rd, 32'hBEEF_0CFD);
    chk("R9 pt read addr", {p_we, p_addr}, {1'b0, 16'h0CFD});
    chk("R9 no cfg request", req_count, n);
    chk("R9 cfg ports not forwarded", pt_bad, 0);
  endtask

  initial begin
    #5_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_selector();
    t_disabled();
    t_read(8'h03, 5'h05, 3'h2, 8'h47);
    t_read(8'hFF, 5'h1E, 3'h7, 8'hFC);
    t_write();
    t_absent();
    t_stall();
    t_passthrough();
    chk("R10 single cycle ack", ack_extra, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule